// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 memory interface. It walks the device from a held reset to a state where the memory can accept normal traffic. It drives the active-low device reset, clock enable, on-die termination enable and a command, bank and address bus. Every wait in the bring-up is a parameter counted in controller clock cycles. The block times the reset hold, the settle time before clock enable, the exit time before the first mode-register write, the four mode-register writes, the long ZQ calibration and the final calibration and DLL lock wait.

A one-cycle `start` pulse begins a sequence. The `warm` input is sampled in the same cycle. It selects the short reset hold used when supply power never dropped, or the long hold used after a power-on ramp. Apart from the hold, both paths are identical. A later `start` pulse at any point restarts from the reset hold. When the last wait ends, `init_done` rises and stays high.

Command codes on `mem_cmd` are `{cs_n, ras_n, cas_n, we_n}`: deselect 4'b1111, no-operation 4'b0111, mode-register set 4'b0000, ZQ calibration 4'b0110 with `mem_addr[10]`=1 selecting the long form.

Top module: `ddr3_init_seq`

## Requirements
- R1: After controller reset, and until `start` is seen, `mem_reset_n`=0, `mem_cke`=0, `mem_odt`=0, `mem_cmd`=deselect (4'b1111) and `init_done`=0.
- R2: With `warm`=0 at `start`, `mem_reset_n` is low for exactly P_RST_COLD cycles, counted from the cycle after `start` is sampled.
- R3: With `warm`=1 at `start`, `mem_reset_n` is low for exactly P_RST_WARM cycles.
- R4: `mem_cke` is low whenever `mem_reset_n` is low. It stays low for exactly P_CKE_DLY cycles after `mem_reset_n` rises, then goes high.
- R5: The first mode-register set (4'b0000) comes exactly max(P_TXS, 5) cycles after `mem_cke` rises.
- R6: Exactly four mode-register sets are issued. Their bank addresses are 2, 3, 1, 0 in that order, and `mem_addr` carries P_MR2, P_MR3, P_MR1, P_MR0 with them. Consecutive sets are exactly P_TMRD cycles apart.
- R7: The ZQ calibration command (4'b0110, `mem_addr[10]`=1, bank 0) comes exactly P_TMOD cycles after the last mode-register set.
- R8: `init_done` rises exactly max(P_TZQINIT, P_TDLLK) cycles after the ZQ calibration cycle. It then stays high, with no-operation on the bus, until the next `start`.
- R9: While `mem_cke` is low the bus carries only deselect. While it is high, every cycle that is not a mode-register set or ZQ calibration carries no-operation. `mem_odt` stays low throughout.
- R10: A `start` pulse in any state (mid-sequence or after ready) makes `mem_reset_n`, `mem_cke` and `init_done` low in the next cycle, and a complete new sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| start | input | 1 | One-cycle request to (re)run the bring-up |
| warm | input | 1 | Sampled with `start`: 1 selects the short reset hold |
| mem_reset_n | output | 1 | Active-low device reset |
| mem_cke | output | 1 | Device clock enable |
| mem_odt | output | 1 | Device termination enable, held low |
| mem_cmd | output | 4 | `{cs_n, ras_n, cas_n, we_n}` command code |
| mem_ba | output | BA_W | Bank address (mode-register select) |
| mem_addr | output | ADDR_W | Address bus (mode value, or bit 10 for ZQ) |
| init_done | output | 1 | High once the device is ready |

## Verification
All outputs are decoded directly from the state register. Each result therefore appears on the clock edge that ends the preceding wait, with no extra pipeline delay. The bench samples every output on the falling edge and stamps each event with a count of rising edges. The reset release must appear P_RST edges after the edge that took `start`. Clock enable follows P_CKE_DLY edges later, the first mode write max(P_TXS,5) edges after that, and each further mode write P_TMRD edges apart. ZQ calibration comes P_TMOD edges after the last mode write, and ready comes max(P_TZQINIT,P_TDLLK) edges after ZQ calibration. The bench compares the differences of these stamps with values computed from its own parameters, so every timing check is exact to the cycle rather than a bound.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_HOLD,
    ST_CKE_WAIT,
    ST_XPR_WAIT,
    ST_MRS_ISSUE,
    ST_MRD_GAP,
    ST_MOD_GAP,
    ST_ZQCL_ISSUE,
    ST_ZQ_WAIT,
    ST_READY
  } init_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_DES  = 4'b1111;
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_MRS  = 4'b0000;
  localparam logic [3:0] CMD_ZQCL = 4'b0110;

  localparam int unsigned ZQ_LONG_BIT = 10;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_delay_timer.sv
// Shared down-counter: loaded with N on entry to a state, flags the
// state's last cycle, so the state lasts N cycles (N >= 1).
module init_delay_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_q > CNT_W'(1)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q <= CNT_W'(1));

endmodule

// File: rtl/init_mr_select.sv
// Maps the write index to the mandatory register order 2, 3, 1, 0.
module init_mr_select #(
  parameter int unsigned              ADDR_W = 14,
  parameter int unsigned              BA_W   = 3,
  parameter logic [ADDR_W-1:0]        P_MR0  = '0,
  parameter logic [ADDR_W-1:0]        P_MR1  = '0,
  parameter logic [ADDR_W-1:0]        P_MR2  = '0,
  parameter logic [ADDR_W-1:0]        P_MR3  = '0
) (
  input  logic [1:0]        idx,
  output logic [BA_W-1:0]   mr_ba,
  output logic [ADDR_W-1:0] mr_val
);

  always_comb begin
    case (idx)
      2'd0:    begin mr_ba = BA_W'(2); mr_val = P_MR2; end
      2'd1:    begin mr_ba = BA_W'(3); mr_val = P_MR3; end
      2'd2:    begin mr_ba = BA_W'(1); mr_val = P_MR1; end
      default: begin mr_ba = BA_W'(0); mr_val = P_MR0; end
    endcase
  end

endmodule

// File: rtl/init_cmd_encoder.sv
// Moore decode of the pins from the sequencer state.
module init_cmd_encoder
  import ddr3_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned BA_W   = 3
) (
  input  init_state_e       state,
  input  logic [BA_W-1:0]   mr_ba,
  input  logic [ADDR_W-1:0] mr_val,
  output logic              mem_reset_n,
  output logic              mem_cke,
  output logic              mem_odt,
  output logic [3:0]        mem_cmd,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done
);

  always_comb begin
    mem_reset_n = 1'b1;
    mem_cke     = 1'b1;
    mem_odt     = 1'b0;
    mem_cmd     = CMD_NOP;
    mem_ba      = '0;
    mem_addr    = '0;
    init_done   = 1'b0;
    case (state)
      ST_IDLE, ST_RST_HOLD: begin
        mem_reset_n = 1'b0;
        mem_cke     = 1'b0;
        mem_cmd     = CMD_DES;
      end
      ST_CKE_WAIT: begin
        mem_cke = 1'b0;
        mem_cmd = CMD_DES;
      end
      ST_MRS_ISSUE: begin
        mem_cmd  = CMD_MRS;
        mem_ba   = mr_ba;
        mem_addr = mr_val;
      end
      ST_ZQCL_ISSUE: begin
        mem_cmd               = CMD_ZQCL;
        mem_addr[ZQ_LONG_BIT] = 1'b1;
      end
      ST_READY: begin
        init_done = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 14,
  parameter int unsigned       BA_W       = 3,
  parameter int unsigned       P_RST_COLD = 160000,
  parameter int unsigned       P_RST_WARM = 80,
  parameter int unsigned       P_CKE_DLY  = 400000,
  parameter int unsigned       P_TXS      = 96,
  parameter int unsigned       P_TMRD     = 4,
  parameter int unsigned       P_TMOD     = 12,
  parameter int unsigned       P_TZQINIT  = 512,
  parameter int unsigned       P_TDLLK    = 512,
  parameter logic [ADDR_W-1:0] P_MR0      = 14'h0520,
  parameter logic [ADDR_W-1:0] P_MR1      = 14'h0044,
  parameter logic [ADDR_W-1:0] P_MR2      = 14'h0008,
  parameter logic [ADDR_W-1:0] P_MR3      = 14'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              warm,
  output logic              mem_reset_n,
  output logic              mem_cke,
  output logic              mem_odt,
  output logic [3:0]        mem_cmd,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done
);

  localparam int unsigned T_XPR  = umax(P_TXS, 5);
  localparam int unsigned T_ZQ   = umax(P_TZQINIT, P_TDLLK);
  localparam int unsigned T_MAX  = umax(umax(umax(P_RST_COLD, P_RST_WARM), umax(P_CKE_DLY, T_XPR)),
                                        umax(umax(P_TMRD, P_TMOD), T_ZQ));
  localparam int unsigned CNT_W  = $clog2(T_MAX + 1);

  localparam logic [CNT_W-1:0] L_COLD = CNT_W'(P_RST_COLD);
  localparam logic [CNT_W-1:0] L_WARM = CNT_W'(P_RST_WARM);
  localparam logic [CNT_W-1:0] L_CKE  = CNT_W'(P_CKE_DLY);
  localparam logic [CNT_W-1:0] L_XPR  = CNT_W'(T_XPR);
  localparam logic [CNT_W-1:0] L_MRD  = CNT_W'(P_TMRD - 1);
  localparam logic [CNT_W-1:0] L_MOD  = CNT_W'(P_TMOD - 1);
  localparam logic [CNT_W-1:0] L_ZQ   = CNT_W'(T_ZQ - 1);

  init_state_e       state_q, state_d;
  logic [1:0]        idx_q, idx_d;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_exp;
  logic [BA_W-1:0]   mr_ba;
  logic [ADDR_W-1:0] mr_val;

  init_delay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  init_mr_select #(
    .ADDR_W (ADDR_W), .BA_W (BA_W),
    .P_MR0 (P_MR0), .P_MR1 (P_MR1), .P_MR2 (P_MR2), .P_MR3 (P_MR3)
  ) u_mr_sel (
    .idx    (idx_q),
    .mr_ba  (mr_ba),
    .mr_val (mr_val)
  );

  init_cmd_encoder #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
    .state       (state_q),
    .mr_ba       (mr_ba),
    .mr_val      (mr_val),
    .mem_reset_n (mem_reset_n),
    .mem_cke     (mem_cke),
    .mem_odt     (mem_odt),
    .mem_cmd     (mem_cmd),
    .mem_ba      (mem_ba),
    .mem_addr    (mem_addr),
    .init_done   (init_done)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (start) begin
      state_d  = ST_RST_HOLD;
      idx_d    = '0;
      tmr_load = 1'b1;
      tmr_val  = warm ? L_WARM : L_COLD;
    end else begin
      case (state_q)
        ST_RST_HOLD: if (tmr_exp) begin
          state_d  = ST_CKE_WAIT;
          tmr_load = 1'b1;
          tmr_val  = L_CKE;
        end
        ST_CKE_WAIT: if (tmr_exp) begin
          state_d  = ST_XPR_WAIT;
          tmr_load = 1'b1;
          tmr_val  = L_XPR;
        end
        ST_XPR_WAIT: if (tmr_exp) begin
          state_d = ST_MRS_ISSUE;
        end
        ST_MRS_ISSUE: begin
          idx_d    = idx_q + 2'd1;
          tmr_load = 1'b1;
          if (idx_q == 2'd3) begin
            state_d = ST_MOD_GAP;
            tmr_val = L_MOD;
          end else begin
            state_d = ST_MRD_GAP;
            tmr_val = L_MRD;
          end
        end
        ST_MRD_GAP: if (tmr_exp) begin
          state_d = ST_MRS_ISSUE;
        end
        ST_MOD_GAP: if (tmr_exp) begin
          state_d = ST_ZQCL_ISSUE;
        end
        ST_ZQCL_ISSUE: begin
          state_d  = ST_ZQ_WAIT;
          tmr_load = 1'b1;
          tmr_val  = L_ZQ;
        end
        ST_ZQ_WAIT: if (tmr_exp) begin
          state_d = ST_READY;
        end
        default: ;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

endmodule

// File: rtl/init_seq_checker.sv
module init_seq_checker
  import ddr3_init_pkg::*;
#(
  parameter int unsigned BA_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            mem_reset_n,
  input logic            mem_cke,
  input logic            mem_odt,
  input logic [3:0]      mem_cmd,
  input logic [BA_W-1:0] mem_ba,
  input logic            zq_a10,
  input logic            init_done
);

  a_r4_cke_low_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_reset_n |-> !mem_cke);

  a_r9_des_when_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cke |-> (mem_cmd == CMD_DES));

  a_r9_legal_when_cke_high: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cke |-> (mem_cmd == CMD_NOP || mem_cmd == CMD_MRS || mem_cmd == CMD_ZQCL));

  a_r9_odt_low: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !mem_odt);

  a_r6_mrs_not_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_MRS) |=> (mem_cmd != CMD_MRS));

  a_r7_zqcl_long_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_ZQCL) |-> (zq_a10 && mem_ba == '0));

  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !start) |=> init_done);

  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!mem_reset_n && !mem_cke && !init_done));

endmodule

bind ddr3_init_seq init_seq_checker #(.BA_W(BA_W)) u_init_seq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .mem_reset_n (mem_reset_n),
  .mem_cke     (mem_cke),
  .mem_odt     (mem_odt),
  .mem_cmd     (mem_cmd),
  .mem_ba      (mem_ba),
  .zq_a10      (mem_addr[10]),
  .init_done   (init_done)
);

// File: tb/test_ddr3_init_seq.sv
module test_ddr3_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 14;
  localparam int BA_W   = 3;
  localparam int COLD = 40, WARM = 8, CKE_DLY = 30, TXS = 3;
  localparam int TMRD = 4, TMOD = 12, TZQINIT = 64, TDLLK = 80;
  localparam int EXP_XPR = 5;   // max(TXS, 5)
  localparam int EXP_ZQ  = 80;  // max(TZQINIT, TDLLK)
  localparam logic [ADDR_W-1:0] MR0 = 14'h0520, MR1 = 14'h0044, MR2 = 14'h0008, MR3 = 14'h0000;
  localparam logic [3:0] DES = 4'b1111, NOP = 4'b0111, MRS = 4'b0000, ZQCL = 4'b0110;

  logic clk, rst_n, start, warm;
  logic mem_reset_n, mem_cke, mem_odt, init_done;
  logic [3:0] mem_cmd;
  logic [BA_W-1:0] mem_ba;
  logic [ADDR_W-1:0] mem_addr;

  ddr3_init_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .P_RST_COLD(COLD), .P_RST_WARM(WARM),
    .P_CKE_DLY(CKE_DLY), .P_TXS(TXS), .P_TMRD(TMRD), .P_TMOD(TMOD),
    .P_TZQINIT(TZQINIT), .P_TDLLK(TDLLK),
    .P_MR0(MR0), .P_MR1(MR1), .P_MR2(MR2), .P_MR3(MR3)
  ) i_ddr3_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .warm(warm),
    .mem_reset_n(mem_reset_n), .mem_cke(mem_cke), .mem_odt(mem_odt),
    .mem_cmd(mem_cmd), .mem_ba(mem_ba), .mem_addr(mem_addr), .init_done(init_done)
  );

  int checks = 0, errors = 0, cyc = 0;
  int t0, t_rst, t_cke, t_zq, t_done, mrs_n, bad_bus, zq_a10;
  int mrs_t[4];
  int mrs_ba[4];
  int mrs_addr[4];
  logic prev_rst = 1'b0, prev_cke = 1'b0, prev_done = 1'b0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Event recorder, sampled away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_reset_n && !prev_rst) t_rst = cyc;
      if (mem_cke && !prev_cke) t_cke = cyc;
      if (init_done && !prev_done) t_done = cyc;
      if (mem_cmd == MRS) begin
        if (mrs_n < 4) begin
          mrs_t[mrs_n] = cyc; mrs_ba[mrs_n] = int'(mem_ba); mrs_addr[mrs_n] = int'(mem_addr);
        end
        mrs_n++;
      end
      if (mem_cmd == ZQCL) begin t_zq = cyc; zq_a10 = int'(mem_addr[10]); end
      if (!mem_cke && mem_cmd != DES) bad_bus++;
      if (mem_cke && !(mem_cmd == NOP || mem_cmd == MRS || mem_cmd == ZQCL)) bad_bus++;
      if (mem_odt) bad_bus++;
    end
    prev_rst = mem_reset_n; prev_cke = mem_cke; prev_done = init_done;
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  task automatic pulse_start(input logic w);
    @(negedge clk); #1;
    t_rst = -1; t_cke = -1; t_zq = -1; t_done = -1; mrs_n = 0; bad_bus = 0; zq_a10 = 0;
    start = 1'b1; warm = w;
    t0 = cyc + 1;
    @(negedge clk); #1;
    start = 1'b0; warm = 1'b0;
    // R10: the edge that took start already drove the device into reset
    chk(!mem_reset_n && !mem_cke && !init_done, "R10 outputs after start", int'({mem_reset_n, mem_cke, init_done}), 0);
  endtask

  task automatic check_seq(input int hold, input string tag);
    int n = 0;
    while (t_done < 0 && n < 2000) begin @(negedge clk); #1; n++; end
    chk(t_rst - t0 == hold, {tag, " reset hold"}, t_rst - t0, hold);
    chk(t_cke - t_rst == CKE_DLY, "R4 cke delay after reset release", t_cke - t_rst, CKE_DLY);
    chk(mrs_t[0] - t_cke == EXP_XPR, "R5 first MRS after cke", mrs_t[0] - t_cke, EXP_XPR);
    chk(mrs_n == 4, "R6 MRS count", mrs_n, 4);
    chk(mrs_ba[0] == 2 && mrs_ba[1] == 3 && mrs_ba[2] == 1 && mrs_ba[3] == 0, "R6 bank order",
        mrs_ba[0]*1000 + mrs_ba[1]*100 + mrs_ba[2]*10 + mrs_ba[3], 2310);
    chk(mrs_addr[0] == int'(MR2) && mrs_addr[1] == int'(MR3), "R6 MR2/MR3 values", mrs_addr[0], int'(MR2));
    chk(mrs_addr[2] == int'(MR1) && mrs_addr[3] == int'(MR0), "R6 MR1/MR0 values", mrs_addr[3], int'(MR0));
    for (int i = 1; i < 4; i++)
      chk(mrs_t[i] - mrs_t[i-1] == TMRD, "R6 MRS spacing", mrs_t[i] - mrs_t[i-1], TMRD);
    chk(t_zq - mrs_t[3] == TMOD, "R7 ZQCL after MR0", t_zq - mrs_t[3], TMOD);
    chk(zq_a10 == 1, "R7 ZQCL long flag", zq_a10, 1);
    chk(t_done - t_zq == EXP_ZQ, "R8 done after ZQCL", t_done - t_zq, EXP_ZQ);
    chk(bad_bus == 0, "R9 bus/ODT legality", bad_bus, 0);
    repeat (20) @(negedge clk);
    #1;
    chk(init_done && mem_cmd == NOP, "R8 done holds with NOP", int'(init_done), 1);
  endtask

  task automatic test_reset_state();
    repeat (10) begin
      @(negedge clk); #1;
    end
    chk(!mem_reset_n && !mem_cke && !mem_odt && !init_done, "R1 reset pins", int'({mem_reset_n, mem_cke, mem_odt, init_done}), 0);
    chk(mem_cmd == DES, "R1 deselect in idle", int'(mem_cmd), int'(DES));
  endtask

  task automatic test_cold();
    pulse_start(1'b0);
    check_seq(COLD, "R2");
  endtask

  task automatic test_warm_after_ready();
    pulse_start(1'b1);   // issued from the ready state
    check_seq(WARM, "R3");
  endtask

  task automatic test_restart_mid();
    int n = 0;
    pulse_start(1'b0);
    while (mrs_n < 2 && n < 500) begin @(negedge clk); #1; n++; end
    chk(mrs_n == 2, "R10 reached mid-sequence", mrs_n, 2);
    pulse_start(1'b1);
    check_seq(WARM, "R10 R3 restarted");
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; warm = 1'b0;
    t_rst = -1; t_cke = -1; t_zq = -1; t_done = -1; mrs_n = 0; bad_bus = 0; zq_a10 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset_state();
    test_cold();
    test_warm_after_ready();
    test_restart_mid();
    finish_run();
  end

endmodule